// File: doc/BRIEF.md
# Trigger Event Qualifier

This block watches four trigger sources and turns them into one single-cycle event pulse. Two of the sources are asynchronous external pins: pin 0 (Ti) and pin 1 (To). The other two are on-chip strobes, one from an ADC path and one from a logic analyser. For each external pin, a 20-bit configuration word can enable any mix of five conditions: low level, high level, any edge, rising edge and falling edge. Each of the four sources also has its own enable bit.

The external pins pass through a reset-cleared synchroniser. Edge conditions compare the synchronised value with its sample from the previous cycle. A pin's conditions are ORed together, and the four gated sources are ORed into one "trigger active" term.

The output pulses for one cycle on each rising transition of that term. A level that stays true, or several conditions that overlap, therefore produce a single event. After reset, all conditions are held off until the synchroniser and the history register hold real samples of the pins.

Top module: `trig_event_qualifier`

## Requirements
- R1: A change on an external pin reaches the output after the synchroniser. With SYNC_STAGES=2, a pin edge that meets an enabled edge condition makes `trig_pulse` high in the third cycle after the change is sampled, and low again in the fourth.
- R2: Config bit 6 (pin 0) and bit 7 (pin 1) enable a rising-edge condition. A falling edge on the same pin gives no event.
- R3: Config bit 8 (pin 0) and bit 9 (pin 1) enable a falling-edge condition. A rising edge on the same pin gives no event.
- R4: Config bit 4 (pin 0) and bit 5 (pin 1) enable an any-edge condition. Both the rising and the falling edge give one event each.
- R5: Config bit 0 (pin 0) enables low-level detection, and bit 2 (pin 0) and bit 3 (pin 1) enable high-level detection (bit 1 is pin 1's low-level enable). A condition that becomes true gives exactly one event, whether it was a pin change or a config change that made it true. Holding the level gives no further events.
- R6: Bit 16 enables pin 0 as a source and bit 17 enables pin 1. With a pin's source bit clear, none of its conditions can cause an event, whatever its mode bits are.
- R7: Bit 18 enables the ADC strobe and bit 19 the logic-analyser strobe. Neither strobe is synchronised. A rising enabled strobe gives `trig_pulse` high in the first cycle after it is sampled. A strobe held high gives only that one event.
- R8: `trig_pulse` is never high for two consecutive cycles. Conditions that are true at the same time, or that hand over from one to the next, merge into one event.
- R9: With config bits 19:16 all clear, `trig_pulse` never asserts.
- R10: While reset is high, `trig_pulse` is low. For SYNC_STAGES+1 cycles after reset is released, no condition is evaluated. A pin held steady through reset gives no edge event. A level condition that is already true once this window ends gives one event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_word | input | 20 | Mode and source enables; field positions are given in the requirements |
| ext_pins | input | 2 | Asynchronous external trigger pins, bit 0 = Ti, bit 1 = To |
| adc_trig | input | 1 | ADC trigger strobe, synchronous to clk |
| la_trig | input | 1 | Logic-analyser trigger strobe, synchronous to clk |
| trig_pulse | output | 1 | Single-cycle trigger event |

## Verification
The bench builds the block with the default SYNC_STAGES=2. With that setting, the pin-to-event latency is exactly three cycles and the start-up blanking window is three cycles, so the bench can check both at a fixed cycle. The table walk counts events in a window that covers that latency, and it steps through every condition type, disabled sources, merged conditions and config-driven level entry. The directed tests then pin down the exact latencies and the behaviour across reset.

// File: rtl/trigq_pkg.sv
package trigq_pkg;

    localparam int NUM_PINS  = 2;
    localparam int NUM_SRC   = 4;
    localparam int CFG_W     = 20;

    // Bit positions of the configuration fields (decoded by the register side)
    localparam int LOW_LSB   = 0;
    localparam int HIGH_LSB  = 2;
    localparam int ANY_LSB   = 4;
    localparam int RISE_LSB  = 6;
    localparam int FALL_LSB  = 8;
    localparam int SRC_LSB   = 16;

    typedef enum logic [1:0] {
        SRC_PIN0 = 2'd0,
        SRC_PIN1 = 2'd1,
        SRC_ADC  = 2'd2,
        SRC_LA   = 2'd3
    } trig_src_e;

    typedef struct packed {
        logic low;
        logic high;
        logic any;
        logic rise;
        logic fall;
    } pin_mode_t;

    typedef struct packed {
        logic [NUM_SRC-1:0] src_en;
        pin_mode_t [NUM_PINS-1:0] pin_mode;
    } trig_cfg_t;

    function automatic trig_cfg_t decode_cfg(input logic [CFG_W-1:0] w);
        trig_cfg_t c;
        for (int p = 0; p < NUM_PINS; p++) begin
            c.pin_mode[p].low  = w[LOW_LSB  + p];
            c.pin_mode[p].high = w[HIGH_LSB + p];
            c.pin_mode[p].any  = w[ANY_LSB  + p];
            c.pin_mode[p].rise = w[RISE_LSB + p];
            c.pin_mode[p].fall = w[FALL_LSB + p];
        end
        c.src_en = w[SRC_LSB +: NUM_SRC];
        return c;
    endfunction

endpackage

// File: rtl/trigq_sync.sv
module trigq_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage_q[0] <= '0;
                    else     stage_q[0] <= async_in;
                end
            end else begin : g_chain
                always_ff @(posedge clk) begin
                    if (rst) stage_q[s] <= '0;
                    else     stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];

    initial begin
        AST_MIN_STAGES: assert (STAGES >= 2) else $error("synchroniser needs two stages"); // R1
    end
endmodule

// File: rtl/trigq_pin_cond.sv
module trigq_pin_cond
    import trigq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      ready,
    input  logic      pin_s,
    input  pin_mode_t mode,
    output logic      cond,
    output logic      ev_rise,
    output logic      ev_fall
);
    logic prev_q;
    logic ev_any;
    logic lvl_low;
    logic lvl_high;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= pin_s;
    end

    always_comb begin
        ev_rise  = ready &  pin_s & ~prev_q;
        ev_fall  = ready & ~pin_s &  prev_q;
        ev_any   = ev_rise | ev_fall;
        lvl_low  = ready & ~pin_s;
        lvl_high = ready &  pin_s;
        cond     = (mode.low  & lvl_low)  |
                   (mode.high & lvl_high) |
                   (mode.any  & ev_any)   |
                   (mode.rise & ev_rise)  |
                   (mode.fall & ev_fall);
    end

    AST_FALL_IS_REAL: assert property (@(posedge clk) disable iff (rst)
        ev_fall |-> $fell(pin_s)) else $error("fall event without a fall"); // R3
endmodule

// File: rtl/trig_event_qualifier.sv
module trig_event_qualifier
    import trigq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CFG_W-1:0] cfg_word,
    input  logic [1:0]       ext_pins,
    input  logic             adc_trig,
    input  logic             la_trig,
    output logic             trig_pulse
);
    localparam int READY_CYC = SYNC_STAGES + 1;
    localparam int CNT_W     = $clog2(READY_CYC + 1);

    trig_cfg_t           cfg;
    logic [NUM_PINS-1:0] pin_s;
    logic [NUM_PINS-1:0] pin_cond;
    logic [NUM_PINS-1:0] pin_rise;
    logic [NUM_PINS-1:0] pin_fall;
    logic [NUM_SRC-1:0]  src_hit;
    logic [CNT_W-1:0]    ready_cnt;
    logic                ready;
    logic                active;
    logic                active_q;

    assign cfg = decode_cfg(cfg_word);

    trigq_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (ext_pins),
        .sync_out (pin_s)
    );

    // Blank conditions until synchroniser and history hold real samples
    always_ff @(posedge clk) begin
        if (rst)                            ready_cnt <= '0;
        else if (ready_cnt != CNT_W'(READY_CYC)) ready_cnt <= ready_cnt + 1'b1;
    end
    assign ready = (ready_cnt == CNT_W'(READY_CYC));

    generate
        for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
            trigq_pin_cond u_cond (
                .clk     (clk),
                .rst     (rst),
                .ready   (ready),
                .pin_s   (pin_s[p]),
                .mode    (cfg.pin_mode[p]),
                .cond    (pin_cond[p]),
                .ev_rise (pin_rise[p]),
                .ev_fall (pin_fall[p])
            );

            AST_RISE_IS_REAL: assert property (@(posedge clk) disable iff (rst)
                pin_rise[p] |-> $rose(pin_s[p])) else $error("rise event without a rise"); // R2
        end
    endgenerate

    always_comb begin
        src_hit[SRC_PIN0] = cfg.src_en[SRC_PIN0] & pin_cond[0];
        src_hit[SRC_PIN1] = cfg.src_en[SRC_PIN1] & pin_cond[1];
        src_hit[SRC_ADC]  = cfg.src_en[SRC_ADC]  & adc_trig & ready;
        src_hit[SRC_LA]   = cfg.src_en[SRC_LA]   & la_trig  & ready;
        active            = |src_hit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q   <= 1'b0;
            trig_pulse <= 1'b0;
        end else begin
            active_q   <= active;
            trig_pulse <= active & ~active_q;
        end
    end

    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
        trig_pulse |=> !trig_pulse) else $error("event longer than one cycle"); // R8
    AST_NO_SOURCE_QUIET: assert property (@(posedge clk) disable iff (rst)
        ($past(cfg_word[SRC_LSB +: NUM_SRC]) == '0) |-> !trig_pulse) else $error("event with sources off"); // R9
    AST_BLANK_QUIET: assert property (@(posedge clk) disable iff (rst)
        !ready |-> !trig_pulse) else $error("event during start-up blanking"); // R10
    AST_RESET_LOW: assert property (@(posedge clk)
        $past(rst) |-> !trig_pulse) else $error("event out of reset"); // R10
endmodule

// File: tb/tb_trig_event_qualifier.sv
`timescale 1ns/1ps
module tb_trig_event_qualifier;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [19:0] cfg_word = '0;
    logic [1:0]  ext_pins = '0;
    logic        adc_trig = 1'b0;
    logic        la_trig  = 1'b0;
    logic        trig_pulse;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    trig_event_qualifier dut (
        .clk(clk), .rst(rst), .cfg_word(cfg_word), .ext_pins(ext_pins),
        .adc_trig(adc_trig), .la_trig(la_trig), .trig_pulse(trig_pulse)
    );

    localparam logic [19:0] B0 = 20'h1;
    // Vector: {cfg[19:0], pins[1:0], adc, la, expected events[1:0]}
    localparam int NVEC = 24;
    localparam logic [25:0] VEC [NVEC] = '{
        {(B0<<16)|(B0<<6), 2'b01, 1'b0, 1'b0, 2'd1},  // R2 rise pin0
        {(B0<<16)|(B0<<6), 2'b00, 1'b0, 1'b0, 2'd0},  // R2 fall ignored
        {(B0<<16)|(B0<<8), 2'b01, 1'b0, 1'b0, 2'd0},  // R3 rise ignored
        {(B0<<16)|(B0<<8), 2'b00, 1'b0, 1'b0, 2'd1},  // R3 fall pin0
        {(B0<<17)|(B0<<5), 2'b10, 1'b0, 1'b0, 2'd1},  // R4 any rise pin1
        {(B0<<17)|(B0<<5), 2'b00, 1'b0, 1'b0, 2'd1},  // R4 any fall pin1
        {(B0<<17)|(B0<<3), 2'b10, 1'b0, 1'b0, 2'd1},  // R5 high entry
        {(B0<<17)|(B0<<3), 2'b10, 1'b0, 1'b0, 2'd0},  // R5 high held
        {(B0<<17)|(B0<<3), 2'b00, 1'b0, 1'b0, 2'd0},  // R5 high left
        {(B0<<16)|(B0<<0), 2'b00, 1'b0, 1'b0, 2'd1},  // R5 low entered by config
        {(B0<<16)|(B0<<0), 2'b01, 1'b0, 1'b0, 2'd0},  // R5 low left
        {(B0<<16)|(B0<<0), 2'b00, 1'b0, 1'b0, 2'd1},  // R5 low entered by pin
        {(B0<<6),          2'b01, 1'b0, 1'b0, 2'd0},  // R6 pin0 source off
        {(B0<<16)|(B0<<7), 2'b11, 1'b0, 1'b0, 2'd0},  // R6 pin1 source off
        {(B0<<18),         2'b11, 1'b1, 1'b0, 2'd1},  // R7 adc rise
        {(B0<<18),         2'b11, 1'b1, 1'b0, 2'd0},  // R7 adc held
        {(B0<<18),         2'b11, 1'b0, 1'b0, 2'd0},  // R7 adc low
        {(B0<<19),         2'b11, 1'b0, 1'b1, 2'd1},  // R7 la rise
        {(B0<<18),         2'b11, 1'b1, 1'b1, 2'd0},  // R8 hand-over merges
        {20'h0,            2'b00, 1'b0, 1'b0, 2'd0},  // R9 all off
        {20'h0,            2'b11, 1'b1, 1'b1, 2'd0},  // R9 all off, toggles
        {20'h003FF,        2'b00, 1'b0, 1'b0, 2'd0},  // R6 modes without sources
        {20'h300C0,        2'b11, 1'b0, 1'b0, 2'd1},  // R8 two rises merge
        {20'h300C0,        2'b00, 1'b0, 1'b0, 2'd0}   // R8 falls ignored
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic count_events(input int cycles, output int n);
        n = 0;
        for (int c = 0; c < cycles; c++) begin
            @(negedge clk);
            if (trig_pulse) n++;
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int n;
        // R10: output low in reset
        repeat (3) @(negedge clk);
        check(trig_pulse == 1'b0, "R10 reset", trig_pulse, 0);
        rst = 1'b0;
        count_events(8, n);
        check(n == 0, "R10 idle after reset", n, 0);

        for (int v = 0; v < NVEC; v++) begin
            @(negedge clk);
            cfg_word = VEC[v][25:6];
            ext_pins = VEC[v][5:4];
            adc_trig = VEC[v][3];
            la_trig  = VEC[v][2];
            count_events(6, n);
            check(n == int'(VEC[v][1:0]), $sformatf("table vector %0d", v), n, int'(VEC[v][1:0]));
        end

        // R1: exact pin-to-event latency
        @(negedge clk);
        cfg_word = (B0<<16)|(B0<<6); ext_pins = 2'b00; adc_trig = 0; la_trig = 0;
        repeat (6) @(negedge clk);
        ext_pins = 2'b01;
        @(negedge clk); check(trig_pulse == 0, "R1 cycle1", trig_pulse, 0);
        @(negedge clk); check(trig_pulse == 0, "R1 cycle2", trig_pulse, 0);
        @(negedge clk); check(trig_pulse == 1, "R1 cycle3", trig_pulse, 1);
        @(negedge clk); check(trig_pulse == 0, "R1 cycle4", trig_pulse, 0);

        // R7: strobe latency one cycle
        cfg_word = (B0<<18); ext_pins = 2'b00;
        repeat (6) @(negedge clk);
        adc_trig = 1'b1;
        @(negedge clk); check(trig_pulse == 1, "R7 adc cycle1", trig_pulse, 1);
        @(negedge clk); check(trig_pulse == 0, "R7 adc cycle2", trig_pulse, 0);
        adc_trig = 1'b0;

        // R10: steady high pin through reset gives no edge event
        cfg_word = (B0<<16)|(B0<<6); ext_pins = 2'b01;
        do_reset();
        count_events(10, n);
        check(n == 0, "R10 no edge from cleared history", n, 0);

        // R10: level already true after blanking gives one event
        cfg_word = (B0<<16)|(B0<<2);
        do_reset();
        count_events(10, n);
        check(n == 1, "R10 level true at start", n, 1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule